// File: doc/BRIEF.md
# Readout Multiplexer Load Sequencer

This block drives the readout side of a sampled-capacitor pipeline. When the trigger queue holds a tagged column number and the sequencer is free, it pops the oldest entry and latches it as the read address. It then steps through a fixed load sequence: the readout line and amplifier are first reset, a single quiet cycle follows, and the column is then read into the readout multiplexer. Once loaded, the multiplexer reports ready. Transmission begins only when three conditions hold in the same cycle: the transmit enable, the multiplexer enable and the token.

A transmission lasts a fixed number of channel cycles. Its last cycle is marked by an end pulse. In that same cycle the sequencer pops the next tagged column, if one is waiting, so that loading restarts without an idle gap. The column that was just sent is kept in a release register. A return-token line is shared by every chip in a daisy chain. When that line is seen high at a falling edge of the slow readout clock, the held column is offered back to the write side through a one-cycle untag request. Both the readout clock and the return-token line are sampled through a synchronizer in the main clock domain. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `rdmux_load_seq`

## Requirements
- R1: While reset is applied, and right after it, the sequencer is idle. All strobes and phase outputs are low, `rd_col` is 0, and no column is pending release.
- R2: While `fifo_empty` is high in idle, `fifo_pop` stays low and the sequencer stays idle.
- R3: In idle with `fifo_empty` low, `fifo_pop` is high for one cycle. `rd_col` takes the value `fifo_col` had in that cycle from the next cycle on, and holds it until the next pop.
- R4: After a pop, `ph_reset` is high for exactly RST_CYC cycles (default 2). Then both phase outputs are low for PAUSE_CYC cycles (default 1). Then `ph_read` is high for READ_CYC cycles (default 2).
- R5: `mux_ready` is high from the cycle after the read phase until the cycle in which `tx_start` fires, both included.
- R6: `tx_start` is high in a cycle only if `mux_ready`, `tx_en`, `mux_en` and `token_in` are all high in that cycle. When all four are high, it fires.
- R7: After `tx_start`, `tx_active` is high for exactly TX_LEN cycles. `tx_done` is high only in the last of those cycles.
- R8: In the `tx_done` cycle, if `fifo_empty` is low, `fifo_pop` is high and `ph_reset` rises in the next cycle. Otherwise the sequencer returns to idle.
- R9: `tx_done` sets a pending release holding `rd_col`. The inputs `rclk_in` and `ret_token_in` pass through SYNC_STAGES flops (default 2). A falling edge of the synchronized `rclk_in`, with the synchronized `ret_token_in` high and a release pending, raises `untag_req` for one cycle with `untag_col` equal to the held column. That clears the pending release.
- R10: `ret_token_in` has no effect when no release is pending or when no synchronized falling edge of `rclk_in` occurs. `untag_req` stays low.
- R11: If `untag_req` fires in the same cycle as `tx_done`, the old column is released and the new column becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main (sampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Trigger queue holds no column |
| fifo_col | input | COL_W | Oldest queued column (show-ahead) |
| fifo_pop | output | 1 | Removes the oldest queued column |
| tx_en | input | 1 | Transmit enable |
| mux_en | input | 1 | Multiplexer enable |
| token_in | input | 1 | Token held by this chip |
| rclk_in | input | 1 | Readout clock, sampled |
| ret_token_in | input | 1 | Shared daisy-chain return-token line |
| rd_col | output | COL_W | Read address of the column being loaded or sent |
| ph_reset | output | 1 | Readout line and amplifier reset phase |
| ph_read | output | 1 | Read phase |
| mux_ready | output | 1 | Multiplexer loaded, waiting to send |
| tx_start | output | 1 | Transmission start strobe |
| tx_active | output | 1 | Transmission in progress |
| tx_done | output | 1 | Last transmission cycle |
| untag_req | output | 1 | Release request for `untag_col` |
| untag_col | output | COL_W | Column offered back for writing |

## Verification
The bench goes after these corner cases:
- **Back-to-back columns.** A queue that already holds the next column when `tx_done` fires. A design that drops the immediate pop would insert an idle cycle. One that pops late would read a stale head.
- **Partial transmit gate.** Cycles where only two of the three gate inputs are high while the multiplexer is ready. A missing term in the gate would start transmission too early.
- **Unrelated return tokens.** The return token toggles before any transmission, and also while `rclk_in` is steady. A wrong edge detector, or a missing pending flag, would emit spurious untag requests.
- **Release coinciding with a new end.** An untag and a new `tx_done` land in the same cycle. A wrong priority would lose one column or release the wrong one.

// File: rtl/rdmux_pkg.sv
package rdmux_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_RST   = 3'd1,
    SEQ_PAUSE = 3'd2,
    SEQ_READ  = 3'd3,
    SEQ_READY = 3'd4,
    SEQ_TX    = 3'd5
  } seq_state_t;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rdmux_phase_fsm.sv
module rdmux_phase_fsm
  import rdmux_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int RST_CYC   = 2,
  parameter int PAUSE_CYC = 1,
  parameter int READ_CYC  = 2,
  parameter int TX_LEN    = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_empty,
  input  logic [COL_W-1:0] fifo_col,
  input  logic             gate_ok,
  output logic             fifo_pop,
  output logic [COL_W-1:0] rd_col,
  output logic             ph_reset,
  output logic             ph_read,
  output logic             mux_ready,
  output logic             tx_start,
  output logic             tx_active,
  output logic             tx_done
);

  localparam int unsigned MAXLEN = max4(RST_CYC, PAUSE_CYC, READ_CYC, TX_LEN);
  localparam int CNT_W = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam logic [CNT_W-1:0] RST_LAST   = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] PAUSE_LAST = CNT_W'(PAUSE_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LAST  = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(TX_LEN - 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             col_en;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q + 1'b1;
    fifo_pop  = 1'b0;
    col_en    = 1'b0;
    ph_reset  = 1'b0;
    ph_read   = 1'b0;
    mux_ready = 1'b0;
    tx_start  = 1'b0;
    tx_active = 1'b0;
    tx_done   = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        cnt_d = '0;
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          col_en   = 1'b1;
          st_d     = SEQ_RST;
        end
      end
      SEQ_RST: begin
        ph_reset = 1'b1;
        if (cnt_q == RST_LAST) begin
          st_d  = SEQ_PAUSE;
          cnt_d = '0;
        end
      end
      SEQ_PAUSE: begin
        if (cnt_q == PAUSE_LAST) begin
          st_d  = SEQ_READ;
          cnt_d = '0;
        end
      end
      SEQ_READ: begin
        ph_read = 1'b1;
        if (cnt_q == READ_LAST) begin
          st_d  = SEQ_READY;
          cnt_d = '0;
        end
      end
      SEQ_READY: begin
        mux_ready = 1'b1;
        cnt_d     = '0;
        if (gate_ok) begin
          tx_start = 1'b1;
          st_d     = SEQ_TX;
        end
      end
      SEQ_TX: begin
        tx_active = 1'b1;
        if (cnt_q == TX_LAST) begin
          tx_done = 1'b1;
          cnt_d   = '0;
          if (!fifo_empty) begin
            fifo_pop = 1'b1;
            col_en   = 1'b1;
            st_d     = SEQ_RST;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
      end
      default: begin
        st_d  = SEQ_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_col <= '0;
    end else if (col_en) begin
      rd_col <= fifo_col;
    end
  end

endmodule

// File: rtl/rdmux_edge_sync.sv
module rdmux_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rclk_in,
  input  logic ret_token_in,
  output logic rt_hit
);

  logic [SYNC_STAGES-1:0] rclk_sh, rt_sh;
  logic                   rclk_prev;
  logic                   rclk_cur, rt_cur;

  assign rclk_cur = rclk_sh[SYNC_STAGES-1];
  assign rt_cur   = rt_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rclk_sh   <= '0;
      rt_sh     <= '0;
      rclk_prev <= 1'b0;
    end else begin
      rclk_sh   <= {rclk_sh[SYNC_STAGES-2:0], rclk_in};
      rt_sh     <= {rt_sh[SYNC_STAGES-2:0], ret_token_in};
      rclk_prev <= rclk_cur;
    end
  end

  assign rt_hit = rclk_prev & ~rclk_cur & rt_cur;

endmodule

// File: rtl/rdmux_release.sv
module rdmux_release #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_done,
  input  logic [COL_W-1:0] rd_col,
  input  logic             rt_hit,
  output logic             untag_req,
  output logic [COL_W-1:0] untag_col
);

  logic pend_q, pend_d;
  logic hold_en;

  assign untag_req = pend_q & rt_hit;
  assign hold_en   = tx_done;

  always_comb begin
    pend_d = pend_q;
    if (untag_req) pend_d = 1'b0;
    if (tx_done)   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       untag_col <= '0;
    else if (hold_en) untag_col <= rd_col;
  end

endmodule

// File: rtl/rdmux_load_seq.sv
module rdmux_load_seq #(
  parameter int COL_W       = 8,
  parameter int RST_CYC     = 2,
  parameter int PAUSE_CYC   = 1,
  parameter int READ_CYC    = 2,
  parameter int TX_LEN      = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_empty,
  input  logic [COL_W-1:0] fifo_col,
  output logic             fifo_pop,
  input  logic             tx_en,
  input  logic             mux_en,
  input  logic             token_in,
  input  logic             rclk_in,
  input  logic             ret_token_in,
  output logic [COL_W-1:0] rd_col,
  output logic             ph_reset,
  output logic             ph_read,
  output logic             mux_ready,
  output logic             tx_start,
  output logic             tx_active,
  output logic             tx_done,
  output logic             untag_req,
  output logic [COL_W-1:0] untag_col
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       gate_ok;
  logic       rt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign gate_ok = tx_en & mux_en & token_in;

  rdmux_phase_fsm #(
    .COL_W(COL_W), .RST_CYC(RST_CYC), .PAUSE_CYC(PAUSE_CYC),
    .READ_CYC(READ_CYC), .TX_LEN(TX_LEN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .fifo_empty(fifo_empty), .fifo_col(fifo_col), .gate_ok(gate_ok),
    .fifo_pop(fifo_pop), .rd_col(rd_col),
    .ph_reset(ph_reset), .ph_read(ph_read), .mux_ready(mux_ready),
    .tx_start(tx_start), .tx_active(tx_active), .tx_done(tx_done)
  );

  rdmux_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .rclk_in(rclk_in), .ret_token_in(ret_token_in), .rt_hit(rt_hit)
  );

  rdmux_release #(.COL_W(COL_W)) u_rel (
    .clk(clk), .rst_n(rst_int_n),
    .tx_done(tx_done), .rd_col(rd_col), .rt_hit(rt_hit),
    .untag_req(untag_req), .untag_col(untag_col)
  );

endmodule

// File: rtl/rdmux_load_seq_chk.sv
module rdmux_load_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic             tx_en,
  input logic             mux_en,
  input logic             token_in,
  input logic [COL_W-1:0] rd_col,
  input logic             ph_reset,
  input logic             ph_read,
  input logic             mux_ready,
  input logic             tx_start,
  input logic             tx_active,
  input logic             tx_done,
  input logic             untag_req
);

  // R2
  empty_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_pop);

  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_reset && ph_read));

  // R4
  pause_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_reset) |-> !ph_read && !mux_ready);

  // R5
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_ready |-> !ph_reset && !ph_read && !tx_active);

  // R6
  gate_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> mux_ready && tx_en && mux_en && token_in);

  // R7
  done_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_active);

  // R3
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tx_done) |=> $stable(rd_col));

  // R8
  chain_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !fifo_empty) |-> fifo_pop);

  // R9
  untag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    untag_req |=> !untag_req);

endmodule

bind rdmux_load_seq rdmux_load_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
  .tx_en(tx_en), .mux_en(mux_en), .token_in(token_in), .rd_col(rd_col),
  .ph_reset(ph_reset), .ph_read(ph_read), .mux_ready(mux_ready),
  .tx_start(tx_start), .tx_active(tx_active), .tx_done(tx_done),
  .untag_req(untag_req)
);

// File: tb/rdmux_load_seq_test.sv
module rdmux_load_seq_test;

  localparam int CW   = 8;
  localparam int TXL  = 6;
  localparam int SYN  = 2;
  localparam int RSTC = 2, PAUC = 1, RDC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic fifo_empty;
  logic [CW-1:0] fifo_col;
  logic fifo_pop, tx_en, mux_en, token_in, rclk_in, ret_token_in;
  logic [CW-1:0] rd_col, untag_col;
  logic ph_reset, ph_read, mux_ready, tx_start, tx_active, tx_done, untag_req;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rdmux_load_seq #(.COL_W(CW), .RST_CYC(RSTC), .PAUSE_CYC(PAUC),
                   .READ_CYC(RDC), .TX_LEN(TXL), .SYNC_STAGES(SYN)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_col(fifo_col),
    .fifo_pop(fifo_pop), .tx_en(tx_en), .mux_en(mux_en), .token_in(token_in),
    .rclk_in(rclk_in), .ret_token_in(ret_token_in), .rd_col(rd_col),
    .ph_reset(ph_reset), .ph_read(ph_read), .mux_ready(mux_ready),
    .tx_start(tx_start), .tx_active(tx_active), .tx_done(tx_done),
    .untag_req(untag_req), .untag_col(untag_col)
  );

  // bench-side trigger queue
  int q[$];

  // reference state
  int m_st, m_cnt, m_col, m_prev;
  bit m_pend, m_rprev;
  bit [SYN-1:0] m_rs, m_rt;
  bit e_pop, e_phd, e_phr, e_rdy, e_start, e_act, e_done, e_untag;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int last_of(input int st);
    case (st)
      1: return RSTC - 1;
      2: return PAUC - 1;
      3: return RDC - 1;
      default: return TXL - 1;
    endcase
  endfunction

  task automatic eval();
    bit empty;
    empty = (q.size() == 0);
    {e_pop, e_phd, e_phr, e_rdy, e_start, e_act, e_done} = '0;
    case (m_st)
      0: e_pop = !empty;
      1: e_phd = 1;
      3: e_phr = 1;
      4: begin e_rdy = 1; e_start = tx_en && mux_en && token_in; end
      5: begin
        e_act  = 1;
        e_done = (m_cnt == TXL - 1);
        e_pop  = e_done && !empty;
      end
      default: ;
    endcase
    e_untag = m_pend && m_rprev && !m_rs[SYN-1] && m_rt[SYN-1];
  endtask

  task automatic compare();
    chk("R2/R3/R8", "fifo_pop", fifo_pop, e_pop);
    chk("R4", "ph_reset", ph_reset, e_phd);
    chk("R4", "ph_read", ph_read, e_phr);
    chk("R5", "mux_ready", mux_ready, e_rdy);
    chk("R6", "tx_start", tx_start, e_start);
    chk("R7", "tx_active", tx_active, e_act);
    chk("R7", "tx_done", tx_done, e_done);
    chk("R3", "rd_col", rd_col, m_col);
    chk("R9/R10", "untag_req", untag_req, e_untag);
    if (e_untag) chk("R9/R11", "untag_col", untag_col, m_prev);
  endtask

  task automatic step();
    int head;
    head = (q.size() != 0) ? q[0] : 0;
    if (e_untag) m_pend = 0;
    if (e_done) begin m_pend = 1; m_prev = m_col; end
    case (m_st)
      0: if (e_pop) begin m_st = 1; m_cnt = 0; end
      1, 2, 3: begin
        if (m_cnt == last_of(m_st)) begin m_st = m_st + 1; m_cnt = 0; end
        else m_cnt++;
      end
      4: if (e_start) begin m_st = 5; m_cnt = 0; end
      5: begin
        if (e_done) begin m_st = e_pop ? 1 : 0; m_cnt = 0; end
        else m_cnt++;
      end
      default: ;
    endcase
    if (e_pop) begin m_col = head; void'(q.pop_front()); end
    m_rprev = m_rs[SYN-1];
    m_rs = {m_rs[SYN-2:0], rclk_in};
    m_rt = {m_rt[SYN-2:0], ret_token_in};
  endtask

  task automatic drive_q();
    fifo_empty = (q.size() == 0);
    fifo_col   = (q.size() != 0) ? CW'(q[0]) : '0;
  endtask

  // one cycle: drive at negedge, check, advance reference at posedge
  task automatic cycle();
    drive_q();
    #1;
    eval();
    compare();
    @(posedge clk);
    step();
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; fifo_empty = 1'b1; fifo_col = '0; tx_en = 0; mux_en = 0;
    token_in = 0; rclk_in = 0; ret_token_in = 0;
    m_st = 0; m_cnt = 0; m_col = 0; m_prev = 0; m_pend = 0; m_rprev = 0;
    m_rs = '0; m_rt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "fifo_pop", fifo_pop, 0);
    chk("R1", "ph_reset", ph_reset, 0);
    chk("R1", "tx_active", tx_active, 0);
    chk("R1", "rd_col", rd_col, 0);
    chk("R1", "untag_req", untag_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: empty queue, gate open, sequencer stays idle
    tx_en = 1; mux_en = 1; token_in = 1;
    repeat (8) cycle();
    // R10: return-token toggling with nothing pending
    ret_token_in = 1;
    for (int i = 0; i < 12; i++) begin rclk_in = ~rclk_in; cycle(); end
    // R6: partial gate while ready
    q.push_back(8'h8C); tx_en = 1; mux_en = 1; token_in = 0;
    repeat (10) cycle();
    token_in = 1; mux_en = 0; repeat (3) cycle();
    mux_en = 1; tx_en = 0; repeat (3) cycle();
    // R8: back-to-back columns, R9/R11 release around chained ends
    q.push_back(8'h00); q.push_back(8'h55);
    tx_en = 1;
    for (int i = 0; i < 60; i++) begin
      rclk_in = (i % 4) < 2; cycle();
    end
    // random mix
    for (int i = 0; i < 8000; i++) begin
      if (q.size() < 8 && ($urandom % 12) == 0) q.push_back($urandom % 141);
      tx_en    = ($urandom % 4) != 0;
      mux_en   = ($urandom % 4) != 0;
      token_in = ($urandom % 3) != 0;
      if (($urandom % 3) == 0) rclk_in = ~rclk_in;
      ret_token_in = $urandom % 2;
      cycle();
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule